// File: doc/BRIEF.md
# Three-Level Nested Vectored Interrupt Controller

This controller gathers interrupt flags from peripherals into ten vector slots. Each slot owns a group of source flags, each with its own enable bit. A slot requests while any of its enabled flags is set. Every slot is given one of two priority levels by a select bit. The first two slots choose between the top level and the bottom level. All other slots choose between the middle level and the bottom level.

The controller keeps track of the level now in service. It accepts a request only when that request's level is strictly above the current level. When it accepts, it raises an acknowledge and shows the slot's vector address to the CPU in that same cycle. The in-service level takes the new value at the next clock edge, and the level that was interrupted is pushed onto a small internal stack. A return strobe pops the stack and restores the interrupted level. A global enable holds off every acceptance, and the flags themselves stay untouched while it is low.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `cur_lvl` is 0 (nothing in service) and `ack` is low. The level codes are 0 = none, 1 = low, 2 = middle, 3 = top.
- R2: Slot s requests while any bit of `src_flag[s*4 +: 4] & src_en[s*4 +: 4]` is 1. A flag whose enable bit is 0 has no effect.
- R3: The vector address of slot s (index 0 to 9) is 0x03 + 8*s, which gives 0x03, 0x0B and so on up to 0x4B.
- R4: When `lvl_sel[s]` is 1, slots 0 and 1 run at level 3 and slots 2 to 9 run at level 2. When `lvl_sel[s]` is 0, any slot runs at level 1. No slot above 1 can reach level 3.
- R5: A request is accepted only if its level is strictly greater than the current level. A request at an equal or lower level waits until the level drops.
- R6: When several slots request at once, the highest level wins. Among slots at the same level, the lowest slot index (smallest address) wins.
- R7: `ack` and `vec_addr` are driven in the same cycle as the acceptance and last exactly that cycle. `cur_lvl` takes the new level at the next clock edge. `vec_addr` is 0 in any cycle without `ack`.
- R8: A pulse on `ret_strobe` restores the level that was interrupted, and nesting can go from none up through all three levels and back. A pulse on `ret_strobe` while `cur_lvl` is 0 has no effect.
- R9: If a request and `ret_strobe` arrive in the same cycle, the request is compared against the restored level rather than the level being left.
- R10: While `glb_en` is 0, no request is accepted. A request still pending when `glb_en` returns to 1 is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global acceptance enable |
| src_flag | input | 40 | Source flags, 4 per slot, slot s at bits [4s+3:4s] |
| src_en | input | 40 | Per-source enables, same layout as `src_flag` |
| lvl_sel | input | 10 | Per-slot level select, 1 = upper level for that slot |
| ret_strobe | input | 1 | Return-from-interrupt pulse |
| ack | output | 1 | Acceptance acknowledge, one cycle |
| vec_addr | output | 8 | Vector address of the accepted slot, 0 otherwise |
| cur_lvl | output | 2 | Level now in service |

## Verification
The return strobe and a new acceptance can fall in the same cycle. In that cycle the controller must pop its stack and decide the request against the restored level. The bench provokes this on purpose: it holds a request at a level equal to the current level, so the request waits, and then pulses the return strobe. The request must then be acknowledged in that very cycle, and the stack beneath must stay as it was. A behavioural model keeps an unbounded queue of interrupted levels, so any mismatch in the acknowledge, the address or the level the controller returns to is flagged on the cycle it happens, during both the directed phases and a long random phase.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSLOT    = 10,
  parameter int NSRC     = 4,
  parameter int NXSLOT   = 2,
  parameter int VW       = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glb_en,
  input  logic [NSLOT*NSRC-1:0] src_flag,
  input  logic [NSLOT*NSRC-1:0] src_en,
  input  logic [NSLOT-1:0]      lvl_sel,
  input  logic                  ret_strobe,
  output logic                  ack,
  output logic [VW-1:0]         vec_addr,
  output logic [1:0]            cur_lvl
);
  localparam int IW = $clog2(NSLOT);
  localparam logic [VW-1:0] VB    = VW'(VEC_BASE);
  localparam logic [VW-1:0] VS    = VW'(VEC_STEP);
  localparam logic [VW-1:0] VTOP  = VW'(VEC_BASE + (NSLOT-1)*VEC_STEP);
  localparam logic [VW-1:0] XLIM  = VW'(VEC_BASE + NXSLOT*VEC_STEP);
  localparam logic [1:0] LV_NONE = 2'd0, LV_LO = 2'd1, LV_MID = 2'd2, LV_TOP = 2'd3;

  logic [NSLOT-1:0] slot_req;
  logic [1:0]       slot_lvl [NSLOT];

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      assign slot_req[g] = |(src_flag[g*NSRC +: NSRC] & src_en[g*NSRC +: NSRC]);
      if (g < NXSLOT) begin : g_top
        assign slot_lvl[g] = lvl_sel[g] ? LV_TOP : LV_LO;
      end else begin : g_mid
        assign slot_lvl[g] = lvl_sel[g] ? LV_MID : LV_LO;
      end
    end
  endgenerate

  logic [1:0]    best_lvl;
  logic [IW-1:0] best_idx;

  always_comb begin
    best_lvl = LV_NONE;
    best_idx = '0;
    for (int s = NSLOT-1; s >= 0; s--) begin
      if (slot_req[s] && slot_lvl[s] >= best_lvl) begin
        best_lvl = slot_lvl[s];
        best_idx = IW'(s);
      end
    end
  end

  logic [1:0] stk0, stk1;
  logic       popping, accept;
  logic [1:0] eff_lvl;

  assign popping  = ret_strobe && (cur_lvl != LV_NONE);
  assign eff_lvl  = popping ? stk0 : cur_lvl;
  assign accept   = glb_en && (best_lvl > eff_lvl);
  assign ack      = accept;
  assign vec_addr = accept ? VB + VS * VW'(best_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= LV_NONE;
      stk0    <= LV_NONE;
      stk1    <= LV_NONE;
    end else if (accept) begin
      cur_lvl <= best_lvl;
      if (!popping) begin
        stk0 <= cur_lvl;
        stk1 <= stk0;
      end
    end else if (popping) begin
      cur_lvl <= stk0;
      stk0    <= stk1;
      stk1    <= LV_NONE;
    end
  end

  a_r5_strict_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ret_strobe) |=> cur_lvl > $past(cur_lvl));
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !ack);
  a_r8_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !ack && cur_lvl != LV_NONE) |=> cur_lvl < $past(cur_lvl));
  a_r3_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vec_addr >= VB) && (vec_addr <= VTOP) && (((vec_addr - VB) % VS) == '0));
  a_r4_top_only_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && vec_addr >= XLIM) |=> cur_lvl != LV_TOP);
  a_r7_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> vec_addr == '0);
  a_r8_idle_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == LV_NONE && !ack) |=> cur_lvl == LV_NONE);
endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  localparam int CLK_P = 10;
  localparam int NSLOT = 10;
  localparam int NSRC  = 4;

  logic clk = 0, rst_n = 0, glb_en = 0, ret_strobe = 0;
  logic [NSLOT*NSRC-1:0] src_flag = '0, src_en = '0;
  logic [NSLOT-1:0] lvl_sel = '0;
  logic ack;
  logic [7:0] vec_addr;
  logic [1:0] cur_lvl;

  int checks = 0, fails = 0;
  int m_cur = 0;
  int m_stk[$];

  always #(CLK_P/2) clk = ~clk;

  irq_nest_ctrl dut (.clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_flag(src_flag),
    .src_en(src_en), .lvl_sel(lvl_sel), .ret_strobe(ret_strobe), .ack(ack),
    .vec_addr(vec_addr), .cur_lvl(cur_lvl));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    int best, bidx, lv, eff, acc;
    bit pop;
    #(CLK_P/4);
    best = 0; bidx = 0;
    for (int s = 0; s < NSLOT; s++) begin
      lv = lvl_sel[s] ? ((s < 2) ? 3 : 2) : 1;
      if (|(src_flag[s*NSRC +: NSRC] & src_en[s*NSRC +: NSRC]) && lv > best) begin
        best = lv; bidx = s;
      end
    end
    pop = ret_strobe && m_cur != 0;
    eff = m_cur;
    if (pop) eff = m_stk[$];
    acc = (glb_en && best > eff) ? 1 : 0;
    chk(tag, "cur_lvl", int'(cur_lvl), m_cur);
    chk(tag, "ack", int'(ack), acc);
    chk(tag, "vec_addr", int'(vec_addr), acc ? 3 + 8*bidx : 0);
    if (pop) void'(m_stk.pop_back());
    if (acc) begin
      m_stk.push_back(eff);
      m_cur = best;
    end else if (pop) m_cur = eff;
    @(negedge clk);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic ret(string tag);
    ret_strobe = 1; step(tag); ret_strobe = 0;
  endtask

  task automatic clr();
    src_flag = '0; src_en = '0; lvl_sel = '0;
  endtask

  initial begin
    #(CLK_P*200000);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", "reset cur_lvl", int'(cur_lvl), 0);
    chk("R1", "reset ack", int'(ack), 0);
    rst_n = 1; glb_en = 1;
    run(2, "R1");
    // R2: flags without enables are ignored
    src_flag[5*4 +: 4] = 4'b1010; src_en[5*4 +: 4] = 4'b0101;
    run(2, "R2");
    src_en[5*4 +: 4] = 4'b0010;
    run(2, "R2");
    clr(); ret("R8"); run(1, "R8");
    // R3/R4: each slot alone, both level selects
    for (int s = 0; s < NSLOT; s++) begin
      for (int h = 0; h < 2; h++) begin
        clr(); src_flag[s*4] = 1'b1; src_en[s*4] = 1'b1; lvl_sel[s] = h[0];
        run(2, "R3"); clr(); ret("R4");
      end
    end
    // R5/R8: nest upward through all levels, equal level waits
    clr();
    src_flag[9*4] = 1; src_en[9*4] = 1;
    run(2, "R5");
    src_flag[3*4] = 1; src_en[3*4] = 1; lvl_sel[3] = 1;
    run(2, "R5");
    src_flag[4*4] = 1; src_en[4*4] = 1; lvl_sel[4] = 1;
    run(2, "R5");
    src_flag[1*4+2] = 1; src_en[1*4+2] = 1; lvl_sel[1] = 1;
    run(2, "R5");
    // R9: return from top while mid request pending (slot 4 waits at level 2)
    src_flag[1*4+2] = 0;
    src_flag[3*4] = 0;
    ret("R9"); run(1, "R9");
    ret("R9"); ret("R8"); ret("R8"); ret("R8"); run(1, "R8");
    // R6: simultaneous requests
    clr();
    src_flag = '1; src_en = '1; lvl_sel = 10'b0000001100;
    run(2, "R6");
    lvl_sel = 10'b1111111111;
    run(2, "R6");
    clr(); ret("R6"); ret("R6"); ret("R6"); run(1, "R6");
    // R10: global enable masks, pending accepted after
    glb_en = 0; src_flag[7*4+1] = 1; src_en[7*4+1] = 1;
    run(3, "R10");
    glb_en = 1; run(2, "R10");
    clr(); ret("R10"); run(1, "R7");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      src_flag = {$urandom, $urandom};
      src_en   = {$urandom, $urandom} & {$urandom, $urandom};
      lvl_sel  = 10'($urandom);
      glb_en   = ($urandom % 8) != 0;
      ret_strobe = ($urandom % 3) == 0;
      step("R7");
    end
    ret_strobe = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule